// File: doc/BRIEF.md
# Byte-Register Watchdog Timer

This block is a hardware watchdog timer reached through a small byte-wide register port. Software sets an enable bit to start a countdown and must keep writing a kick bit before the count runs out. If it stops kicking, the timer expires. In a main instance (`IS_MAIN=1`), expiry drives a reset pulse and records a sticky cause flag. In an auxiliary instance (`IS_MAIN=0`), expiry only raises an alarm flag.

The parameter `FMT` picks how the timeout is held:
- `FMT=0` (exponent): a 4-bit exponent n gives a period of 2^n milliseconds, so the longest period is about 32 s.
- `FMT=1` (8-bit seconds): one byte holds whole seconds.
- `FMT=2` (16-bit seconds): a seconds count is written as a low byte and then a high byte. The high-byte write commits the whole value.

The two seconds formats also report the time left. `CLK_HZ` sets the prescaler that produces the 1 ms or 1 s tick.

The controller is a three-state machine:
- IDLE: stopped.
- RUN: counting down.
- FIRE: the expiry action.

Its transitions are:
- IDLE→RUN: a write of 1 to the enable bit; the counter reloads.
- RUN→IDLE: a write of 0 to the enable bit.
- RUN→FIRE: the count reaches zero on a tick.
- FIRE→IDLE: after `RST_CYC` clocks (main) or after one clock (auxiliary).

Register map (3-bit address):

| Address | Contents |
|---|---|
| 0 | Enable, bit 0 |
| 1 | Kick, bit 0 (write-only) |
| 2 | Timeout, low byte |
| 3 | Timeout, high byte |
| 4 | Time left, low byte |
| 5 | Time left, high byte |
| 6 | Status: bit 0 cause, bit 1 alarm |

Top module: `wdog_timer`

## Requirements
- R1: After reset: the timer is stopped, address 0 reads 0, `wdog_rst` and `alarm` are 0, and address 2 reads the reset timeout `INIT_TMO`.
- R2: A write with bit 0 = 1 to address 0 while stopped starts counting with a fresh reload. A write with bit 0 = 0 stops it, and no expiry follows while it is stopped. Address 0 bit 0 reads 1 only while counting.
- R3: Each write with bit 0 = 1 to address 1 while counting reloads the full timeout. A repeated kick reloads again. Expiry comes exactly timeout × unit clocks after the last reload.
- R4: Exponent format (`FMT=0`): address 2 bits [3:0] hold n, and the period is 2^n ms. Bits [7:4] ignore writes and read 0.
- R5: 8-bit seconds format (`FMT=1`): address 2 holds seconds. The stored value 0 reads back as 0 but counts as 1 second.
- R6: 16-bit seconds format (`FMT=2`): a write to address 2 only stages the low byte. A write to address 3 commits {high, staged low}. Until then, addresses 2 and 3 read the previously committed value.
- R7: In the seconds formats, address 4 returns the low byte of the remaining seconds. Reading it also captures the high byte, which a later read of address 5 returns. In the exponent format, address 4 reads 0.
- R8: On expiry, a main instance drives `wdog_rst` high for exactly `RST_CYC` clocks, starting on the expiry edge, and the timer is then stopped.
- R9: Status bit 0 (cause) sets on a main expiry. It survives `rst_n`, is cleared by writing 1 to bit 0 of address 6, and is cleared by `por_n`.
- R10: An auxiliary instance never drives `wdog_rst`. On expiry it sets `alarm`, which also reads as status bit 1 and is cleared by writing 1 to bit 1 of address 6.
- R11: Writing a new timeout while counting does not reload the counter. The new value first applies at the next kick or start.
- R12: Read data appears on `rdata` after the clock edge that samples `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the cause flag |
| rst_n | input | 1 | Functional reset, active low; clears all but the cause flag |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| wdog_rst | output | 1 | Reset pulse on expiry (main instance only) |
| alarm | output | 1 | Alarm flag on expiry (auxiliary instance only) |

## Verification
The bench builds three instances side by side, each with a deliberately small `CLK_HZ`:
- 16-bit seconds, main, `CLK_HZ=20`: one second is 20 clocks, so exact expiry cycles, kicks, stop/start, the staged high-byte commit, the time-left snapshot across a high-byte rollover and the sticky cause flag all fit in a few thousand cycles.
- Exponent format, auxiliary, `CLK_HZ=4000`: one millisecond is 4 clocks, which puts a 2^3 ms expiry and the alarm path within 32 clocks.
- 8-bit seconds, main, `CLK_HZ=20`: exercises the zero-treated-as-one rule and the power-on clearing of the cause flag.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int FMT_EXP2  = 0;
    localparam int FMT_SEC8  = 1;
    localparam int FMT_SEC16 = 2;

    localparam int ADDR_W = 3;
    localparam int CNT_W  = 16;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_KICK    = 3'd1;
    localparam logic [ADDR_W-1:0] A_TMO_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_TMO_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_LEFT_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_LEFT_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_STAT    = 3'd6;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIRE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int UNIT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(UNIT_CYC - 1);

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (restart || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int RST_CYC = 16,
    parameter bit IS_MAIN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_p,
    input  logic             stop_p,
    input  logic             kick_p,
    input  logic             tick,
    input  logic [CNT_W-1:0] tmo_load,
    output logic [CNT_W-1:0] cnt,
    output logic             reload,
    output logic             expire,
    output logic             running,
    output logic             wdog_rst
);
    localparam int FIRE_LEN = IS_MAIN ? RST_CYC : 1;
    localparam int FW = $clog2(FIRE_LEN + 1);
    localparam logic [FW-1:0] FIRE_LAST = FW'(FIRE_LEN - 1);

    wd_state_e st, st_nx;
    logic [FW-1:0] fire_cnt;
    logic fire_done;

    assign fire_done = (fire_cnt == FIRE_LAST);
    assign reload = (st == S_IDLE && start_p) || (st == S_RUN && kick_p && !stop_p);
    assign expire = (st == S_RUN) && !stop_p && !kick_p && tick && (cnt == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (start_p) st_nx = S_RUN;
            S_RUN:  if (stop_p) st_nx = S_IDLE;
                    else if (expire) st_nx = S_FIRE;
            S_FIRE: if (fire_done) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running  = (st == S_RUN);
        wdog_rst = IS_MAIN && (st == S_FIRE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            fire_cnt <= '0;
        end else begin
            if (reload)
                cnt <= tmo_load;
            else if (st == S_RUN && tick)
                cnt <= cnt - 1'b1;
            if (st == S_FIRE) fire_cnt <= fire_cnt + 1'b1;
            else              fire_cnt <= '0;
        end
    end

    assert_run_cnt_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN) |-> (cnt != '0));
    assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt == $past(tmo_load)));
    assert_rst_from_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdog_rst) |-> ($past(st) == S_RUN));
    assert_idle_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && $past(st) == S_IDLE) |-> $stable(cnt));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int FMT      = FMT_SEC16,
    parameter bit IS_MAIN  = 1'b1,
    parameter int INIT_TMO = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              running,
    input  logic              expire,
    input  logic [CNT_W-1:0]  cnt,
    output logic [7:0]        rdata,
    output logic              start_p,
    output logic              stop_p,
    output logic              kick_p,
    output logic [CNT_W-1:0]  tmo_load,
    output logic              alarm_q
);
    localparam bit HAS_LEFT = (FMT != FMT_EXP2);

    logic [7:0] tmo_lo_rd, tmo_hi_rd, snap_hi;
    logic cause_q;
    logic wr_ctrl, wr_stat;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign start_p = wr_ctrl && wdata[0];
    assign stop_p  = wr_ctrl && !wdata[0];
    assign kick_p  = wr_en && (addr == A_KICK) && wdata[0];

    generate
        if (FMT == FMT_EXP2) begin : g_exp
            logic [3:0] exp_q;
            logic unused_bits;
            assign unused_bits = ^wdata[7:4];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) exp_q <= 4'(INIT_TMO);
                else if (wr_en && addr == A_TMO_LO) exp_q <= wdata[3:0];
            end
            assign tmo_load  = {{(CNT_W-1){1'b0}}, 1'b1} << exp_q;
            assign tmo_lo_rd = {4'b0, exp_q};
            assign tmo_hi_rd = 8'h00;
        end else if (FMT == FMT_SEC8) begin : g_sec8
            logic [7:0] sec_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sec_q <= 8'(INIT_TMO);
                else if (wr_en && addr == A_TMO_LO) sec_q <= wdata;
            end
            assign tmo_load  = (sec_q == 8'h00) ? CNT_W'(1) : CNT_W'(sec_q);
            assign tmo_lo_rd = sec_q;
            assign tmo_hi_rd = 8'h00;
        end else begin : g_sec16
            logic [7:0]  lo_stage;
            logic [15:0] sec_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lo_stage <= '0;
                    sec_q    <= 16'(INIT_TMO);
                end else if (wr_en && addr == A_TMO_LO) begin
                    lo_stage <= wdata;
                end else if (wr_en && addr == A_TMO_HI) begin
                    sec_q <= {wdata, lo_stage};
                end
            end
            assign tmo_load  = (sec_q == 16'h0) ? CNT_W'(1) : sec_q;
            assign tmo_lo_rd = sec_q[7:0];
            assign tmo_hi_rd = sec_q[15:8];
        end
    endgenerate

    // sticky cause flag: only power-on reset clears it asynchronously
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            cause_q <= 1'b0;
        else if (IS_MAIN && expire)
            cause_q <= 1'b1;
        else if (wr_stat && wdata[0])
            cause_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            alarm_q <= 1'b0;
        else if (!IS_MAIN && expire)
            alarm_q <= 1'b1;
        else if (wr_stat && wdata[1])
            alarm_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata   <= '0;
            snap_hi <= '0;
        end else if (rd_en) begin
            unique case (addr)
                A_CTRL:    rdata <= {7'b0, running};
                A_TMO_LO:  rdata <= tmo_lo_rd;
                A_TMO_HI:  rdata <= tmo_hi_rd;
                A_LEFT_LO: begin
                    rdata   <= HAS_LEFT ? cnt[7:0] : 8'h00;
                    snap_hi <= HAS_LEFT ? cnt[15:8] : 8'h00;
                end
                A_LEFT_HI: rdata <= snap_hi;
                A_STAT:    rdata <= {6'b0, alarm_q, cause_q};
                default:   rdata <= 8'h00;
            endcase
        end
    end

    assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
        (cause_q && !(wr_stat && wdata[0])) |=> cause_q);
    assert_alarm_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q && !(wr_stat && wdata[1])) |=> alarm_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int FMT      = FMT_SEC16,
    parameter bit IS_MAIN  = 1'b1,
    parameter int RST_CYC  = 16,
    parameter int INIT_TMO = 10
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       wdog_rst,
    output logic       alarm
);
    localparam int UNIT_RAW = (FMT == FMT_EXP2) ? (CLK_HZ / 1000) : CLK_HZ;
    localparam int UNIT_CYC = (UNIT_RAW < 1) ? 1 : UNIT_RAW;

    logic rst_core_n;
    logic start_p, stop_p, kick_p, tick, reload, expire, running;
    logic [CNT_W-1:0] cnt, tmo_load;

    assign rst_core_n = rst_n & por_n;

    wdog_tick #(.UNIT_CYC(UNIT_CYC)) u_tick (
        .clk(clk), .rst_n(rst_core_n), .restart(reload), .tick(tick)
    );

    wdog_regs #(.FMT(FMT), .IS_MAIN(IS_MAIN), .INIT_TMO(INIT_TMO)) u_regs (
        .clk(clk), .rst_n(rst_core_n), .por_n(por_n),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .running(running), .expire(expire), .cnt(cnt),
        .rdata(rdata), .start_p(start_p), .stop_p(stop_p), .kick_p(kick_p),
        .tmo_load(tmo_load), .alarm_q(alarm)
    );

    wdog_core #(.RST_CYC(RST_CYC), .IS_MAIN(IS_MAIN)) u_core (
        .clk(clk), .rst_n(rst_core_n),
        .start_p(start_p), .stop_p(stop_p), .kick_p(kick_p), .tick(tick),
        .tmo_load(tmo_load), .cnt(cnt), .reload(reload), .expire(expire),
        .running(running), .wdog_rst(wdog_rst)
    );
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b0;
    logic rd_en = 1'b0;
    logic [2:0] we = 3'b000;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdv [3];
    logic [2:0] rst_o, alm_o;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    // 0: 16-bit seconds main, 1: exponent aux, 2: 8-bit seconds main
    wdog_timer #(.CLK_HZ(20), .FMT(2), .IS_MAIN(1'b1)) u_wdog_timer (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(we[0]), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdv[0]), .wdog_rst(rst_o[0]), .alarm(alm_o[0]));
    wdog_timer #(.CLK_HZ(4000), .FMT(0), .IS_MAIN(1'b0)) u_exp (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(we[1]), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdv[1]), .wdog_rst(rst_o[1]), .alarm(alm_o[1]));
    wdog_timer #(.CLK_HZ(20), .FMT(1), .IS_MAIN(1'b1)) u_s8 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(we[2]), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdv[2]), .wdog_rst(rst_o[2]), .alarm(alm_o[2]));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int i, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we[i] = 1'b1;
        @(posedge clk);
        #1 we[i] = 1'b0;
    endtask

    task automatic rd(input int i, input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        #1 rd_en = 1'b0;
        v = rdv[i];
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 wdog_rst after reset", 16'(rst_o), 16'h0);
        chk("R1 alarm after reset", 16'(alm_o), 16'h0);
        rd(0, 3'd0, v); chk("R1/R12 enable reads 0", 16'(v), 16'h0);
        rd(0, 3'd2, v); chk("R1 timeout reset value", 16'(v), 16'd10);
        rd(1, 3'd2, v); chk("R1 exponent reset value", 16'(v), 16'd10);
    endtask

    task automatic t_sec16_expire;
        logic [7:0] v;
        wr(0, 3'd2, 8'd3); wr(0, 3'd3, 8'd0);
        wr(0, 3'd0, 8'd1);
        wait_cyc(59); chk("R6/R8 no reset before 3 s", 16'(rst_o[0]), 16'h0);
        wait_cyc(1);  chk("R8 reset at 3 s", 16'(rst_o[0]), 16'h1);
        wait_cyc(15); chk("R8 reset still high at clock 16", 16'(rst_o[0]), 16'h1);
        wait_cyc(1);  chk("R8 reset low after 16 clocks", 16'(rst_o[0]), 16'h0);
        rd(0, 3'd0, v); chk("R8 stopped after expiry", 16'(v), 16'h0);
        rd(0, 3'd6, v); chk("R9 cause set", 16'(v), 16'h1);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(0, 3'd6, v); chk("R9 cause survives rst_n", 16'(v), 16'h1);
        wr(0, 3'd6, 8'h01);
        rd(0, 3'd6, v); chk("R9 cause write-1 clear", 16'(v), 16'h0);
    endtask

    task automatic t_stop;
        logic [7:0] v;
        wr(0, 3'd2, 8'd2); wr(0, 3'd3, 8'd0);
        wr(0, 3'd0, 8'd1);
        rd(0, 3'd0, v); chk("R2 enable reads 1 while running", 16'(v), 16'h1);
        wait_cyc(20);
        wr(0, 3'd0, 8'd0);
        wait_cyc(100); chk("R2 no expiry while stopped", 16'(rst_o[0]), 16'h0);
        rd(0, 3'd0, v); chk("R2 enable reads 0 after stop", 16'(v), 16'h0);
        wr(0, 3'd0, 8'd1);
        wait_cyc(39); chk("R2 restart full period (before)", 16'(rst_o[0]), 16'h0);
        wait_cyc(1);  chk("R2 restart full period (at)", 16'(rst_o[0]), 16'h1);
        wait_cyc(20);
    endtask

    task automatic t_kick;
        wr(0, 3'd0, 8'd1);
        wait_cyc(30); wr(0, 3'd1, 8'd1);
        wait_cyc(30); wr(0, 3'd1, 8'd1);
        wait_cyc(39); chk("R3 no expiry before kick+2 s", 16'(rst_o[0]), 16'h0);
        wait_cyc(1);  chk("R3 expiry at kick+2 s", 16'(rst_o[0]), 16'h1);
        wait_cyc(20);
        wr(0, 3'd6, 8'h01);
    endtask

    task automatic t_no_reload;
        logic [7:0] v;
        wr(0, 3'd0, 8'd1);
        wr(0, 3'd2, 8'd5); wr(0, 3'd3, 8'd0);
        wait_cyc(37); chk("R11 old period still applies (before)", 16'(rst_o[0]), 16'h0);
        wait_cyc(1);  chk("R11 old period still applies (at)", 16'(rst_o[0]), 16'h1);
        wait_cyc(20);
        wr(0, 3'd0, 8'd1);
        wait_cyc(99); chk("R11 new period at next start (before)", 16'(rst_o[0]), 16'h0);
        wait_cyc(1);  chk("R11 new period at next start (at)", 16'(rst_o[0]), 16'h1);
        wait_cyc(20);
        wr(0, 3'd2, 8'd9);
        rd(0, 3'd2, v); chk("R6 low byte only staged", 16'(v), 16'd5);
        wr(0, 3'd3, 8'd0);
        rd(0, 3'd2, v); chk("R6 commit on high write", 16'(v), 16'd9);
    endtask

    task automatic t_timeleft;
        logic [7:0] v;
        wr(0, 3'd2, 8'h02); wr(0, 3'd3, 8'h01);
        wr(0, 3'd0, 8'd1);
        rd(0, 3'd4, v); chk("R7 time-left low", 16'(v), 16'h02);
        rd(0, 3'd5, v); chk("R7 time-left high", 16'(v), 16'h01);
        wait_cyc(80);
        rd(0, 3'd5, v); chk("R7 high is snapshot", 16'(v), 16'h01);
        rd(0, 3'd4, v); chk("R7 low after 4 s", 16'(v), 16'hFE);
        rd(0, 3'd5, v); chk("R7 new snapshot high", 16'(v), 16'h00);
        wr(0, 3'd0, 8'd0);
    endtask

    task automatic t_sec8;
        logic [7:0] v;
        wr(2, 3'd2, 8'd0);
        rd(2, 3'd2, v); chk("R5 zero reads back", 16'(v), 16'h0);
        wr(2, 3'd0, 8'd1);
        wait_cyc(19); chk("R5 zero as 1 s (before)", 16'(rst_o[2]), 16'h0);
        wait_cyc(1);  chk("R5 zero as 1 s (at)", 16'(rst_o[2]), 16'h1);
        wait_cyc(20);
        rd(2, 3'd6, v); chk("R9 cause set in 8-bit instance", 16'(v), 16'h1);
        wr(2, 3'd2, 8'd200); wr(2, 3'd0, 8'd1);
        rd(2, 3'd4, v); chk("R7 8-bit time-left", 16'(v), 16'd200);
        rd(2, 3'd5, v); chk("R7 8-bit time-left high", 16'(v), 16'h0);
        wr(2, 3'd0, 8'd0);
        @(negedge clk) por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rd(2, 3'd6, v); chk("R9 por clears cause", 16'(v), 16'h0);
    endtask

    task automatic t_exp;
        logic [7:0] v;
        wr(1, 3'd2, 8'hF3);
        rd(1, 3'd2, v); chk("R4 upper bits ignored", 16'(v), 16'h03);
        wr(1, 3'd0, 8'd1);
        wait_cyc(31); chk("R4 no alarm before 8 ms", 16'(alm_o[1]), 16'h0);
        wait_cyc(1);  chk("R4/R10 alarm at 8 ms", 16'(alm_o[1]), 16'h1);
        chk("R10 aux no reset", 16'(rst_o[1]), 16'h0);
        wait_cyc(20); chk("R10 aux no reset later", 16'(rst_o[1]), 16'h0);
        rd(1, 3'd0, v); chk("R10 aux stopped", 16'(v), 16'h0);
        rd(1, 3'd6, v); chk("R10 status alarm bit", 16'(v), 16'h02);
        rd(1, 3'd4, v); chk("R7 exponent time-left 0", 16'(v), 16'h0);
        wr(1, 3'd6, 8'h02); chk("R10 alarm cleared", 16'(alm_o[1]), 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        #1;
        t_reset();
        t_sec16_expire();
        t_stop();
        t_kick();
        t_no_reload();
        t_timeleft();
        t_sec8();
        t_exp();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule